// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer with Wait States

This block runs one bus transfer at a time for a small 8-bit processor core. The transfer can be a read or a write, to memory or to I/O space. The low byte of the address and the data share one byte-wide lane. Every transfer begins with an address phase: a latch-enable strobe marks the address on the shared lane, so an external latch can hold it. A data phase follows, with an active-low read or write strobe. A slow target holds the `ready` input low to stretch the data phase by whole clock periods. During that stretch every bus output stays exactly as it was.

A transfer with no wait states lasts three clocks: T1 (address), T2 (strobe, `ready` examined) and T3 (data settles). The sequencer examines `ready` on the falling clock edge in the middle of T2, and again in the middle of each inserted wait clock. When it sees `ready` low, it inserts exactly one wait clock. When it sees `ready` high, it goes on to T3. There is no limit on the number of wait clocks. The clock edge that ends T3 does four things: it captures read data, releases the strobe, floats the shared lane and raises `done` for one clock. The shared lane is brought out as separate output, enable and input ports, and the tri-state driver sits at the pad.

Top module: `bus_cycle_seq`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in idle with `ale` low, `rd_n` and `wr_n` high, `ad_oe` low and `done` low.
- R2: A request accepted in idle opens T1 on the next rising edge. In T1, `ale` is 1 for exactly one clock, `addr_hi` carries addr[15:8], `ad_out` carries addr[7:0] with `ad_oe` high, and `io_m` carries `io_sel` (1 = I/O space, 0 = memory).
- R3: In T2, `ale` is 0. When `wr_sel` is 1 (write), `wr_n` goes low and `ad_out` carries the write data with `ad_oe` 1. When `wr_sel` is 0 (read), `rd_n` goes low and `ad_oe` is 0.
- R4: `ready` is sampled on the falling clock edge inside T2. If that sample is high, T3 follows T2 directly, so a zero-wait transfer takes three clocks, T1 to T3.
- R5: Each low sample of `ready` adds exactly one wait clock. `ready` is sampled again on the falling edge of every wait clock, and the number of wait clocks has no limit.
- R6: During a wait clock, `ale`, `rd_n`, `wr_n`, `ad_out`, `ad_oe`, `addr_hi` and `io_m` keep the values they had in the clock before.
- R7: On the rising edge that ends T3, `done` rises for exactly one clock and `rd_n`/`wr_n` return high with `ad_oe` low. In a read, `rdata` takes the `ad_in` value present at that edge. A write leaves `rdata` unchanged.
- R8: A request, address or control change that arrives while a transfer is in progress is ignored. No new T1 begins unless `req` is high in an idle clock.
- R9: `rd_n` and `wr_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request, sampled in idle |
| wr_sel | input | 1 | 1 = write, 0 = read |
| io_sel | input | 1 | 1 = I/O space, 0 = memory |
| addr | input | 16 | Transfer address |
| wdata | input | 8 | Write data |
| ready | input | 1 | Target ready, sampled on falling edges |
| ad_in | input | 8 | Shared lane as seen at the pad |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | Space select of the current transfer |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared lane drive value |
| ad_oe | output | 1 | Shared lane output enable |
| rdata | output | 8 | Captured read data |
| done | output | 1 | One-clock completion pulse |

## Verification
Suppose `req` is driven just after rising edge P0. Then T1 outputs appear after P1 and T2 outputs after P2. With n wait clocks, T3 begins after P3+n, and `done` and `rdata` appear after P4+n, falling again one edge later. The bench drives inputs and samples outputs 1 ns after each rising edge, so the falling-edge sample of `ready` always sees a settled value. Each scenario task walks the transfer one edge at a time and compares the outputs against the state expected at that edge. It checks that the outputs are frozen in every wait clock, and it changes `ad_in` during T3 to show that `rdata` takes only the value present at the final edge.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_TW   = 3'd3,
    S_T3   = 3'd4
  } bcs_state_t;
endpackage

// File: rtl/bcs_ready_smp.sv
// Samples the target-ready input on the falling clock edge, half a clock
// before the rising edge that ends T2 or a wait clock.
module bcs_ready_smp (
  input  logic clk,
  input  logic rst,
  input  logic ready,
  output logic rdy_q
);
  always_ff @(negedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= ready;
  end
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       rdy_q,
  output bcs_state_t state_q,
  output bcs_state_t state_d
);
  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:    if (req) state_d = S_T1;
      S_T1:      state_d = S_T2;
      S_T2, S_TW: state_d = rdy_q ? S_T3 : S_TW;
      S_T3:      state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  // R5: a low ready sample in T2 or a wait clock adds one wait clock
  a_r5_low_adds_wait: assert property (@(posedge clk) disable iff (rst)
    ((state_q == S_T2 || state_q == S_TW) && !rdy_q) |=> (state_q == S_TW));
  // R4: a high sample moves straight on to T3
  a_r4_high_to_t3: assert property (@(posedge clk) disable iff (rst)
    ((state_q == S_T2 || state_q == S_TW) && rdy_q) |=> (state_q == S_T3));
  // R8: a transfer in progress never restarts at T1
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE) |=> (state_q != S_T1));
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bcs_state_t        state_q,
  input  bcs_state_t        state_d,
  input  logic              wr_sel,
  input  logic              io_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic              wr_q;
  logic [DATA_W-1:0] wdat_q;

  // All outputs are registered; each changes only on the edge entering a state.
  always_ff @(posedge clk) begin
    if (rst) begin
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      io_m    <= 1'b0;
      addr_hi <= '0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      rdata   <= '0;
      done    <= 1'b0;
      wr_q    <= 1'b0;
      wdat_q  <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (state_d == S_T1) begin
            ale     <= 1'b1;
            addr_hi <= addr[ADDR_W-1:DATA_W];
            ad_out  <= addr[DATA_W-1:0];
            ad_oe   <= 1'b1;
            io_m    <= io_sel;
            wr_q    <= wr_sel;
            wdat_q  <= wdata;
          end
        end
        S_T1: begin
          ale <= 1'b0;
          if (wr_q) begin
            wr_n   <= 1'b0;
            ad_out <= wdat_q;
            ad_oe  <= 1'b1;
          end else begin
            rd_n  <= 1'b0;
            ad_oe <= 1'b0;
          end
        end
        S_T3: begin
          rd_n  <= 1'b1;
          wr_n  <= 1'b1;
          ad_oe <= 1'b0;
          done  <= 1'b1;
          if (!wr_q) rdata <= ad_in;
        end
        default: ;
      endcase
    end
  end

  // R1: reset leaves the bus quiet
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!ale && rd_n && wr_n && !ad_oe && !done));
  // R6: every bus output frozen during a wait clock
  a_r6_wait_frozen: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_TW) |-> $stable({ale, rd_n, wr_n, io_m, addr_hi, ad_out, ad_oe}));
  // R9: strobes mutually exclusive
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  // R7: done lasts one clock
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2/R3: one-clock ale followed by a strobe
  a_r2_ale_then_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> (!ale && ($fell(rd_n) || $fell(wr_n))));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr_sel,
  input  logic              io_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ready,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic       rdy_q;
  bcs_state_t state_q;
  bcs_state_t state_d;

  bcs_ready_smp u_smp (
    .clk   (clk),
    .rst   (rst),
    .ready (ready),
    .rdy_q (rdy_q)
  );

  bcs_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .rdy_q   (rdy_q),
    .state_q (state_q),
    .state_d (state_d)
  );

  bcs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .state_q (state_q),
    .state_d (state_d),
    .wr_sel  (wr_sel),
    .io_sel  (io_sel),
    .addr    (addr),
    .wdata   (wdata),
    .ad_in   (ad_in),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .io_m    (io_m),
    .addr_hi (addr_hi),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .rdata   (rdata),
    .done    (done)
  );
endmodule

// File: tb/sim_bus_cycle_seq.sv
`timescale 1ns/1ps
module sim_bus_cycle_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, wr_sel = 1'b0, io_sel = 1'b0, ready = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, ad_in = '0;
  logic ale, rd_n, wr_n, io_m, ad_oe, done;
  logic [7:0] addr_hi, ad_out, rdata;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_cycle_seq u0 (
    .clk(clk), .rst(rst), .req(req), .wr_sel(wr_sel), .io_sel(io_sel),
    .addr(addr), .wdata(wdata), .ready(ready), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .rdata(rdata), .done(done)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // One full transfer with nw wait clocks, checked edge by edge.
  task automatic run_cycle(logic w, logic io, logic [15:0] a, logic [7:0] wd,
                           logic [7:0] rd_val, int nw, logic [7:0] prev_rdata);
    logic [31:0] snap;
    req = 1'b1; wr_sel = w; io_sel = io; addr = a; wdata = wd;
    ready = (nw == 0); ad_in = 8'h5A;
    tick();  // T1
    req = 1'b0;
    check("R2 ale", ale, 1);
    check("R2 addr_hi", addr_hi, a[15:8]);
    check("R2 ad_out", ad_out, a[7:0]);
    check("R2 ad_oe", ad_oe, 1);
    check("R2 io_m", io_m, io);
    check("R2 strobes idle", {rd_n, wr_n}, 2'b11);
    tick();  // T2
    check("R3 ale low", ale, 0);
    check("R3 rd_n", rd_n, w);
    check("R3 wr_n", wr_n, !w);
    check("R3 ad_oe", ad_oe, w);
    if (w) check("R3 wdata", ad_out, wd);
    check("R9 exclusive", {rd_n, wr_n} == 2'b00, 0);
    snap = {8'h0, ale, rd_n, wr_n, io_m, addr_hi, ad_out, ad_oe, 1'b0};
    for (int i = 1; i <= nw; i++) begin
      tick();  // wait clock i
      check("R6 frozen", {8'h0, ale, rd_n, wr_n, io_m, addr_hi, ad_out, ad_oe, 1'b0}, snap);
      check("R5 no done in wait", done, 0);
      if (i == nw) ready = 1'b1;
    end
    tick();  // T3
    check("R4 T3 strobe held", {rd_n, wr_n}, w ? 2'b10 : 2'b01);
    check("R4 no done in T3", done, 0);
    ad_in = rd_val;
    tick();  // idle, done
    check("R7 done", done, 1);
    check("R7 strobes released", {rd_n, wr_n, ad_oe}, 3'b110);
    check("R7 rdata", rdata, w ? prev_rdata : rd_val);
    tick();
    check("R7 done one clock", done, 0);
    check("R8 no new cycle", ale, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    check("R1 reset", {ale, rd_n, wr_n, ad_oe, done}, 5'b01100);
    rst = 1'b0;
    tick();
    check("R1 idle after reset", {ale, rd_n, wr_n}, 3'b011);
  endtask

  task automatic t_ignore_mid();
    req = 1'b1; wr_sel = 1'b1; io_sel = 1'b0; addr = 16'h1234; wdata = 8'h77;
    ready = 1'b1;
    tick();  // T1
    req = 1'b0;
    tick();  // T2
    req = 1'b1; addr = 16'hABCD; wr_sel = 1'b0;
    tick();  // T3
    check("R8 addr_hi kept", addr_hi, 8'h12);
    check("R8 strobe kept", {rd_n, wr_n}, 2'b10);
    req = 1'b0;
    tick();  // idle, done
    check("R8 done", done, 1);
    tick();
    check("R8 no restart", ale, 0);
    tick();
    check("R8 still idle", {ale, rd_n, wr_n}, 3'b011);
  endtask

  initial begin
    t_reset();
    run_cycle(1'b0, 1'b0, 16'hC3A5, 8'h00, 8'h3C, 0, 8'h00); // R4 zero-wait read
    run_cycle(1'b1, 1'b1, 16'h00F0, 8'h96, 8'hEE, 0, 8'h3C); // R3 I/O write
    run_cycle(1'b0, 1'b1, 16'h8001, 8'h00, 8'hA7, 1, 8'h3C); // R5 one wait
    run_cycle(1'b1, 1'b0, 16'h7FFE, 8'h11, 8'h00, 3, 8'hA7); // R5 three waits
    run_cycle(1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h42, 12, 8'hA7); // R5 long stretch
    t_ignore_mid();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule